// File: doc/BRIEF.md
# MSI Message Capture Interrupt Generator

This block sits on the write path of a PCIe root port's outbound memory-mapped master. Each message-signalled interrupt that arrives becomes a plain 32-bit write to one of a small, contiguous set of data locations. Every location keeps its own first-in first-out queue of the values written to it, so several vectors can arrive before software services any of them. A writer is never stalled. A value that arrives at a full queue is thrown away, and that location's saturating drop counter records it.

A per-location status vector shows which queues hold unread values. A host-written mask vector selects which locations may raise the interrupt. The single registered, level-sensitive interrupt output stays high while any unmasked location has pending data. The processor reads the status, then drains each flagged location through the same port. Each read pops the oldest value, and reading an empty location returns zero.

The port has a write channel and a read channel that may be active in the same cycle. Writes take effect at the clock edge. Read data is registered and appears one cycle after the read strobe. The asynchronous active-low reset is released through a two-stage synchronizer, so the block responds from the third rising edge after `rst_n` goes high.

Top module: `msi_capture_irq`

## Requirements
- R1: After reset every queue is empty, the status, mask and drop counters read zero, `irq` is low and `rd_data` is zero.
- R2: A write to word address i (0 ≤ i < NUM_LOC) appends `wr_data` to queue i, and each queue holds up to 32 values.
- R3: A read of word address i returns the oldest value of queue i on `rd_data` in the cycle after `rd_en`, and removes that value, so values come back in the order they were written.
- R4: A read of an empty data location returns zero and changes no state.
- R5: The status register at word address NUM_LOC has bit i set exactly while queue i is non-empty. Writes to this address are ignored.
- R6: The mask register at word address NUM_LOC+1 takes bits [NUM_LOC-1:0] of `wr_data` on a write and reads back the same value. A set bit i removes location i from the interrupt.
- R7: `irq` is registered. It is high in the cycle after some location is both non-empty and unmasked, and low in the cycle after no location is.
- R8: A write to a queue that already holds 32 values, with no pop of that queue in the same cycle, is discarded, and the queue's contents and order are unchanged.
- R9: Word address NUM_LOC+2+i reads an 8-bit drop counter for location i. It counts discarded writes, stops at 255, and returns to zero when written with any value.
- R10: A read and a write to the same non-empty location in one cycle pop the oldest value and append the new one, leaving the count unchanged and dropping nothing even when the queue is full. On an empty location the read returns zero and the write is stored.
- R11: Reads of word addresses above NUM_LOC*2+1 return zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe, never back-pressured |
| wr_addr | input | ADDR_W (7) | Word address of the write |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W (7) | Word address of the read |
| rd_data | output | 32 | Registered read data, valid one cycle after `rd_en` |
| irq | output | 1 | Level interrupt request |

## Verification
A queue pointer or count that goes wrong shows on the very next read of that location as an out-of-order or stale value. It also shows within one cycle as a wrong status bit or a wrong `irq` level. A bad full or drop decision shows as a missing or extra value when the queue is drained, and as a wrong drop counter value on the next read of that counter. Because the bench checks `irq` against its model on every cycle, a fault in the mask or status logic is caught one cycle after it first matters.

// File: rtl/msi_pkg.sv
package msi_pkg;
  localparam int DATA_W = 32;
  typedef logic [DATA_W-1:0] word_t;
endpackage

// File: rtl/msi_rst_sync.sv
module msi_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= '0;
    else          sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/msi_loc_queue.sv
module msi_loc_queue
  import msi_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int OVF_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_req,
  input  word_t            push_data,
  input  logic             pop_req,
  input  logic             ovf_clr,
  output word_t            head_o,
  output logic             not_empty_o,
  output logic [OVF_W-1:0] ovf_cnt_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [OVF_W-1:0] OVF_MAX = {OVF_W{1'b1}};

  word_t            mem_q [DEPTH];
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d;
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [OVF_W-1:0] ovf_q, ovf_d;
  logic             full, do_pop, do_push, drop;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // next-state logic
  always_comb begin
    full     = (cnt_q == FULL_CNT);
    do_pop   = pop_req && (cnt_q != '0);
    do_push  = push_req && (!full || do_pop);
    drop     = push_req && full && !do_pop;
    rd_ptr_d = do_pop  ? ptr_inc(rd_ptr_q) : rd_ptr_q;
    wr_ptr_d = do_push ? ptr_inc(wr_ptr_q) : wr_ptr_q;
    unique case ({do_push, do_pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
    if (ovf_clr)                    ovf_d = '0;
    else if (drop && ovf_q != OVF_MAX) ovf_d = ovf_q + 1'b1;
    else                            ovf_d = ovf_q;
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      cnt_q    <= '0;
      ovf_q    <= '0;
    end else begin
      if (do_pop)              rd_ptr_q <= rd_ptr_d;
      if (do_push)             wr_ptr_q <= wr_ptr_d;
      if (do_push != do_pop)   cnt_q    <= cnt_d;
      if (ovf_clr || drop)     ovf_q    <= ovf_d;
    end
  end

  // storage, no reset
  always_ff @(posedge clk) begin
    if (do_push) mem_q[wr_ptr_q] <= push_data;
  end

  assign head_o      = mem_q[rd_ptr_q];
  assign not_empty_o = (cnt_q != '0);
  assign ovf_cnt_o   = ovf_q;

  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL_CNT);

  p_empty_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && !push_req && cnt_q == '0) |=> (cnt_q == '0));

  p_drop_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && !pop_req && cnt_q == FULL_CNT) |=> (cnt_q == FULL_CNT && $stable(rd_ptr_q)));

  p_ovf_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q == OVF_MAX && !ovf_clr) |=> (ovf_q == OVF_MAX));

  p_ovf_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_clr |=> (ovf_q == '0));

  p_same_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && pop_req && cnt_q != '0) |=> $stable(cnt_q));
endmodule

// File: rtl/msi_irq_gen.sv
module msi_irq_gen #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pending_i,
  input  logic         mask_wr,
  input  logic [N-1:0] mask_wdata,
  output logic [N-1:0] mask_o,
  output logic         irq_o
);
  logic [N-1:0] mask_q;
  logic         irq_q, irq_d;

  always_comb begin
    irq_d = |(pending_i & ~mask_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (mask_wr) mask_q <= mask_wdata;
      irq_q <= irq_d;
    end
  end

  assign mask_o = mask_q;
  assign irq_o  = irq_q;

  p_mask_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr |=> (mask_o == $past(mask_wdata)));

  p_irq_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pending_i & ~mask_o)) |=> irq_o);

  p_irq_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(pending_i & ~mask_o)) |=> !irq_o);
endmodule

// File: rtl/msi_capture_irq.sv
module msi_capture_irq
  import msi_pkg::*;
#(
  parameter int NUM_LOC = 4,
  parameter int DEPTH   = 32,
  parameter int OVF_W   = 8,
  parameter int ADDR_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  output logic              irq
);
  localparam int STAT_ADDR = NUM_LOC;
  localparam int MASK_ADDR = NUM_LOC + 1;
  localparam int OVF_BASE  = NUM_LOC + 2;

  logic               rst_n_s;
  logic [NUM_LOC-1:0] wr_hit, rd_hit, clr_hit, not_empty, mask_val;
  word_t              head [NUM_LOC];
  logic [OVF_W-1:0]   ovf_cnt [NUM_LOC];
  logic               mask_wr;
  word_t              rd_data_q, rd_data_d;

  msi_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_s)
  );

  // address decode
  always_comb begin
    for (int i = 0; i < NUM_LOC; i++) begin
      wr_hit[i]  = wr_en && (int'(wr_addr) == i);
      rd_hit[i]  = rd_en && (int'(rd_addr) == i);
      clr_hit[i] = wr_en && (int'(wr_addr) == OVF_BASE + i);
    end
    mask_wr = wr_en && (int'(wr_addr) == MASK_ADDR);
  end

  genvar g;
  generate
    for (g = 0; g < NUM_LOC; g++) begin : g_loc
      msi_loc_queue #(.DEPTH(DEPTH), .OVF_W(OVF_W)) u_queue (
        .clk         (clk),
        .rst_n       (rst_n_s),
        .push_req    (wr_hit[g]),
        .push_data   (wr_data),
        .pop_req     (rd_hit[g]),
        .ovf_clr     (clr_hit[g]),
        .head_o      (head[g]),
        .not_empty_o (not_empty[g]),
        .ovf_cnt_o   (ovf_cnt[g])
      );

      p_status_set_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
        (wr_hit[g] && !not_empty[g]) |=> not_empty[g]);

      p_rd_empty_zero_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
        (rd_hit[g] && !not_empty[g]) |=> (rd_data == '0));
    end
  endgenerate

  msi_irq_gen #(.N(NUM_LOC)) u_irq (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .pending_i  (not_empty),
    .mask_wr    (mask_wr),
    .mask_wdata (wr_data[NUM_LOC-1:0]),
    .mask_o     (mask_val),
    .irq_o      (irq)
  );

  // read mux
  always_comb begin
    rd_data_d = '0;
    for (int i = 0; i < NUM_LOC; i++) begin
      if (int'(rd_addr) == i && not_empty[i]) rd_data_d = head[i];
      if (int'(rd_addr) == OVF_BASE + i) rd_data_d[OVF_W-1:0] = ovf_cnt[i];
    end
    if (int'(rd_addr) == STAT_ADDR) rd_data_d[NUM_LOC-1:0] = not_empty;
    if (int'(rd_addr) == MASK_ADDR) rd_data_d[NUM_LOC-1:0] = mask_val;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)   rd_data_q <= '0;
    else if (rd_en) rd_data_q <= rd_data_d;
  end

  assign rd_data = rd_data_q;
endmodule

// File: tb/msi_capture_irq_tb.sv
module msi_capture_irq_tb_top;
  localparam int NL = 4;
  localparam int QD = 32;
  localparam int OMAX = 255;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [6:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [6:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        irq;

  int n_cmp = 0;
  int n_mis = 0;

  logic [31:0] mq [NL][$];
  int          ovf_m [NL];
  logic [NL-1:0] mask_m = '0;

  always #5 clk = ~clk;

  msi_capture_irq dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_mis++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic model_irq();
    for (int i = 0; i < NL; i++)
      if (mq[i].size() != 0 && !mask_m[i]) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [31:0] model_read(input int a);
    logic [31:0] v = '0;
    if (a < NL) begin
      if (mq[a].size() != 0) v = mq[a][0];
    end else if (a == NL) begin
      for (int i = 0; i < NL; i++) v[i] = (mq[i].size() != 0);
    end else if (a == NL + 1) begin
      v[NL-1:0] = mask_m;
    end else if (a >= NL + 2 && a < 2 * NL + 2) begin
      v = 32'(ovf_m[a - NL - 2]);
    end
    return v;
  endfunction

  // called at a falling edge; applies one cycle and checks
  task automatic cyc(input logic wen, input int wa, input logic [31:0] wd,
                     input logic ren, input int ra, input string tag);
    logic [31:0] er;
    logic        ei;
    ei = model_irq();
    er = model_read(ra);
    wr_en = wen; wr_addr = 7'(wa); wr_data = wd;
    rd_en = ren; rd_addr = 7'(ra);
    if (ren && ra < NL && mq[ra].size() != 0) void'(mq[ra].pop_front());
    if (wen) begin
      if (wa < NL) begin
        if (mq[wa].size() < QD) mq[wa].push_back(wd);
        else if (ovf_m[wa] < OMAX) ovf_m[wa]++;
      end else if (wa == NL + 1) begin
        mask_m = wd[NL-1:0];
      end else if (wa >= NL + 2 && wa < 2 * NL + 2) begin
        ovf_m[wa - NL - 2] = 0;
      end
    end
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    if (ren) chk(tag, rd_data, er);
    chk("R7 irq level", {31'd0, irq}, {31'd0, ei});
  endtask

  task automatic wr(input int a, input logic [31:0] d, input string tag);
    cyc(1'b1, a, d, 1'b0, 0, tag);
  endtask

  task automatic rd(input int a, input string tag);
    cyc(1'b0, 0, '0, 1'b1, a, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_mis++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    $finish;
  end

  initial begin
    for (int i = 0; i < NL; i++) ovf_m[i] = 0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 irq after reset", {31'd0, irq}, 32'd0);
    chk("R1 rd_data after reset", rd_data, 32'd0);
    rd(NL, "R1 status");
    rd(NL + 1, "R1 mask");
    for (int i = 0; i < NL; i++) rd(NL + 2 + i, "R1 drop counter");

    // R2/R3/R4/R5 basic ordering
    wr(1, 32'hA1, "R2 push"); wr(1, 32'hA2, "R2 push"); wr(1, 32'hA3, "R2 push");
    rd(NL, "R5 status after push");
    wr(NL, 32'hFFFF_FFFF, "R5 status write ignored");
    rd(NL, "R5 status unchanged");
    rd(1, "R3 oldest first"); rd(1, "R3 second"); rd(1, "R3 third");
    rd(1, "R4 empty read zero");
    rd(NL, "R5 status cleared");

    // R6 mask
    wr(NL + 1, 32'h2, "R6 mask write");
    rd(NL + 1, "R6 mask readback");
    wr(1, 32'hB1, "R6 masked push");
    cyc(1'b0, 0, '0, 1'b0, 0, "R6 masked irq");
    wr(NL + 1, 32'h0, "R6 unmask");
    cyc(1'b0, 0, '0, 1'b0, 0, "R7 irq after unmask");
    rd(1, "R3 drain");
    cyc(1'b0, 0, '0, 1'b0, 0, "R7 irq fall");

    // R8/R9 overflow on location 2
    for (int i = 0; i < QD; i++) wr(2, 32'h2000 + 32'(i), "R2 fill");
    for (int i = 0; i < 3; i++) wr(2, 32'hDEAD, "R8 drop");
    rd(NL + 2 + 2, "R9 drop count three");
    // R10 full queue read+write
    cyc(1'b1, 2, 32'hC0DE, 1'b1, 2, "R10 full simultaneous");
    rd(NL + 2 + 2, "R10 no drop counted");
    for (int i = 0; i < QD; i++) rd(2, "R8 drain order");
    rd(2, "R4 empty after drain");
    wr(NL + 2 + 2, 32'h1234, "R9 clear");
    rd(NL + 2 + 2, "R9 cleared");
    // R10 on empty location
    cyc(1'b1, 3, 32'h77, 1'b1, 3, "R10 empty simultaneous");
    rd(3, "R10 stored value");

    // R9 saturation on location 0
    for (int i = 0; i < QD; i++) wr(0, 32'(i), "R2 fill");
    for (int i = 0; i < 260; i++) wr(0, 32'hBAD, "R9 saturate");
    rd(NL + 2, "R9 saturated at 255");
    wr(NL + 2, 32'h0, "R9 clear");
    rd(NL + 2, "R9 cleared after saturate");

    // R11 out of range
    wr(100, 32'h5555, "R11 write ignored");
    rd(100, "R11 read zero");
    rd(NL, "R11 status unchanged");

    // random mix
    for (int k = 0; k < 4000; k++) begin
      logic        we, re;
      int          wa, ra;
      logic [31:0] wd;
      we = ($urandom_range(0, 99) < 55);
      re = ($urandom_range(0, 99) < 45);
      wa = ($urandom_range(0, 9) < 8) ? int'($urandom_range(0, NL - 1))
                                      : int'($urandom_range(NL, 2 * NL + 3));
      ra = ($urandom_range(0, 9) < 7) ? int'($urandom_range(0, NL - 1))
                                      : int'($urandom_range(NL, 2 * NL + 3));
      if ($urandom_range(0, 19) == 0) ra = wa;
      wd = $urandom();
      cyc(we, wa, wd, re, ra, "R3 random mix");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    $finish;
  end
endmodule